// File: doc/BRIEF.md
# Multicycle Accumulator Processor Sequencer

This block is a small 8-bit accumulator processor with a 16-bit address space. It steps through a fixed register-transfer sequence to fetch, decode and execute each instruction. Every memory access goes through one synchronous memory port, using an address latch, a data latch, an instruction latch, a program counter, a temporary address register split into low and high bytes, an accumulator and a carry flag.

Three opcodes are defined. 0x9A loads the accumulator from the byte that follows the opcode. 0x8A adds the byte at an absolute address, plus the carry, to the accumulator. 0x84 writes the accumulator to an absolute address. An absolute address is given by the two bytes after the opcode, low byte first. Any other opcode stops the processor in a halt state that only reset clears. The block is meant to be paired with a synchronous memory that returns read data in the cycle after the read strobe.

Top module: `acc_cpu`

## Requirements
- R1: A synchronous active-low reset sets the program counter to 0x0100 and clears the accumulator and the carry flag. While reset is held, `mem_rd`, `mem_wr` and `halted` are low. In the second cycle after reset is released, the first read strobe is presented at address 0x0100.
- R2: Each memory read drives `mem_addr` with `mem_rd` high for exactly one cycle. The block samples `mem_rdata` in the following cycle. `mem_rd` and `mem_wr` are never high together.
- R3: Opcode 0x9A copies the byte at the following address into the accumulator and leaves the carry flag unchanged.
- R4: Opcode 0x8A reads a low address byte, then a high address byte, then the data byte at {high,low}. It sets the accumulator to accumulator + data + carry, modulo 256. The carry flag becomes 1 when the unsigned 8-bit sum overflows and 0 otherwise.
- R5: Opcode 0x84 reads the address bytes in the same low-then-high order. It then raises `mem_wr` for one cycle with `mem_addr` = {high,low} and `mem_wdata` = accumulator. The accumulator and the carry flag are left unchanged.
- R6: Any opcode other than 0x9A, 0x8A or 0x84 moves the block to a halt state. There `halted` is high and stays high, and no further read or write strobe is issued until reset.
- R7: The load instruction makes 2 reads, the add instruction 4 reads, and the store instruction 3 reads and 1 write. The next opcode is fetched from the byte after the last operand, so the program counter advances by 2 or 3.
- R8: Reset applied in the halt state clears `halted`, and execution restarts from 0x0100.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| mem_addr | output | 16 | Memory address, valid with a read or write strobe |
| mem_wdata | output | 8 | Write data, valid with `mem_wr` |
| mem_rdata | input | 8 | Read data, valid the cycle after `mem_rd` |
| mem_rd | output | 1 | One-cycle read strobe |
| mem_wr | output | 1 | One-cycle write strobe |
| halted | output | 1 | High once an undefined opcode has been decoded |

## Verification
Some properties are checked on every cycle: the one-cycle read pulse and the exclusion of read and write, the stickiness and silence of the halt state, the one-step program counter increment, and the add-with-carry arithmetic across the accumulator and flag. Also checked every cycle are carry preservation on a load and the unchanged accumulator and flag around a write. Other behaviour only the bench scenarios can show, through the bytes the processor writes back. This covers the low-then-high address assembly, the carry carried from one instruction to a later one, the per-instruction read counts, the clearing of the accumulator and carry by reset, and the restart after a halt.

// File: rtl/acc_cpu_pkg.sv
// Package: shared widths, opcode values, sequencer states and the
// control word passed from the sequencer to the datapath.
// Assumes an 8-bit data path with a double-width address.
package acc_cpu_pkg;

    localparam int DW = 8;
    localparam int AW = 2 * DW;

    localparam logic [DW-1:0] OPC_LDI = 8'h9A;
    localparam logic [DW-1:0] OPC_ADC = 8'h8A;
    localparam logic [DW-1:0] OPC_STA = 8'h84;

    typedef enum logic [4:0] {
        ST_IF_A, ST_IF_R, ST_IF_D, ST_DEC,
        ST_IM_A, ST_IM_R, ST_IM_D, ST_IM_X,
        ST_LO_A, ST_LO_R, ST_LO_D, ST_LO_X,
        ST_HI_A, ST_HI_R, ST_HI_D, ST_HI_X,
        ST_EA,   ST_DR,   ST_DD,   ST_ADD,
        ST_SW,   ST_WR,   ST_HALT
    } state_t;

    typedef struct packed {
        logic mar_from_pc;
        logic mar_from_tmp;
        logic mbr_from_mem;
        logic mbr_from_ac;
        logic ir_ld;
        logic pc_inc;
        logic ac_from_mbr;
        logic ac_add;
        logic tl_ld;
        logic th_ld;
        logic rd;
        logic wr;
    } ctl_t;

endpackage

// File: rtl/acc_cpu_adder.sv
// Adder: unsigned W-bit add of two operands plus a carry-in, giving a
// W-bit sum and the carry out. Purely combinational.
module acc_cpu_adder #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         ci,
    output logic [W-1:0] sum,
    output logic         co
);

    // Form the W+1 bit total and split it into sum and carry.
    always_comb begin
        {co, sum} = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, ci};
    end

endmodule

// File: rtl/acc_cpu_ctrl.sv
// Sequencer: walks the fixed micro-step sequence and emits one control
// word per cycle. Each memory read takes three states (latch address,
// strobe, capture). Assumes read data arrives the cycle after the strobe.
module acc_cpu_ctrl
    import acc_cpu_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] mbr,
    input  logic [DW-1:0] ir,
    output ctl_t          ctl,
    output logic          halted
);

    state_t st, st_nx;

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IF_A;
        else        st <= st_nx;
    end

    // Next-state and control-word decode for every micro-step.
    always_comb begin
        st_nx = st;
        ctl   = '0;
        unique case (st)
            ST_IF_A: begin ctl.mar_from_pc = 1'b1; st_nx = ST_IF_R; end
            ST_IF_R: begin ctl.rd = 1'b1; ctl.pc_inc = 1'b1; st_nx = ST_IF_D; end
            ST_IF_D: begin ctl.mbr_from_mem = 1'b1; st_nx = ST_DEC; end
            ST_DEC: begin
                ctl.ir_ld = 1'b1;
                if (mbr == OPC_LDI)                         st_nx = ST_IM_A;
                else if (mbr == OPC_ADC || mbr == OPC_STA)  st_nx = ST_LO_A;
                else                                        st_nx = ST_HALT;
            end
            ST_IM_A: begin ctl.mar_from_pc = 1'b1; st_nx = ST_IM_R; end
            ST_IM_R: begin ctl.rd = 1'b1; ctl.pc_inc = 1'b1; st_nx = ST_IM_D; end
            ST_IM_D: begin ctl.mbr_from_mem = 1'b1; st_nx = ST_IM_X; end
            ST_IM_X: begin ctl.ac_from_mbr = 1'b1; st_nx = ST_IF_A; end
            ST_LO_A: begin ctl.mar_from_pc = 1'b1; st_nx = ST_LO_R; end
            ST_LO_R: begin ctl.rd = 1'b1; ctl.pc_inc = 1'b1; st_nx = ST_LO_D; end
            ST_LO_D: begin ctl.mbr_from_mem = 1'b1; st_nx = ST_LO_X; end
            ST_LO_X: begin ctl.tl_ld = 1'b1; st_nx = ST_HI_A; end
            ST_HI_A: begin ctl.mar_from_pc = 1'b1; st_nx = ST_HI_R; end
            ST_HI_R: begin ctl.rd = 1'b1; ctl.pc_inc = 1'b1; st_nx = ST_HI_D; end
            ST_HI_D: begin ctl.mbr_from_mem = 1'b1; st_nx = ST_HI_X; end
            ST_HI_X: begin ctl.th_ld = 1'b1; st_nx = ST_EA; end
            ST_EA: begin
                ctl.mar_from_tmp = 1'b1;
                st_nx = (ir == OPC_ADC) ? ST_DR : ST_SW;
            end
            ST_DR:   begin ctl.rd = 1'b1; st_nx = ST_DD; end
            ST_DD:   begin ctl.mbr_from_mem = 1'b1; st_nx = ST_ADD; end
            ST_ADD:  begin ctl.ac_add = 1'b1; st_nx = ST_IF_A; end
            ST_SW:   begin ctl.mbr_from_ac = 1'b1; st_nx = ST_WR; end
            ST_WR:   begin ctl.wr = 1'b1; st_nx = ST_IF_A; end
            ST_HALT: st_nx = ST_HALT;
            default: st_nx = ST_HALT;
        endcase
    end

    // Halt flag decoded from the sticky state.
    assign halted = (st == ST_HALT);

    assert_halt_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);
    assert_halt_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> (!ctl.rd && !ctl.wr));
    assert_bad_opcode_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DEC && mbr != OPC_LDI && mbr != OPC_ADC && mbr != OPC_STA) |=> halted);
    assert_single_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.rd |=> !ctl.rd);
    assert_no_rdwr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctl.rd && ctl.wr));

endmodule

// File: rtl/acc_cpu_dpath.sv
// Datapath: program counter, address and data latches, instruction
// latch, split temporary address, accumulator and carry flag, all
// loaded under the sequencer's control word. The address output is the
// address latch; the write data output is the data latch.
module acc_cpu_dpath
    import acc_cpu_pkg::*;
#(
    parameter logic [AW-1:0] RESET_PC = 16'h0100
) (
    input  logic          clk,
    input  logic          rst_n,
    input  ctl_t          ctl,
    input  logic [DW-1:0] mem_rdata,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic [DW-1:0] mbr,
    output logic [DW-1:0] ir
);

    logic [AW-1:0] pc, mar;
    logic [DW-1:0] tl, th, ac, sum;
    logic          cf, co;

    acc_cpu_adder #(.W(DW)) u_add (
        .a(ac), .b(mbr), .ci(cf), .sum(sum), .co(co)
    );

    // Program counter: reset vector, then single-step increments.
    always_ff @(posedge clk) begin
        if (!rst_n)          pc <= RESET_PC;
        else if (ctl.pc_inc) pc <= pc + AW'(1);
    end

    // Address latch: from the program counter or the assembled operand address.
    always_ff @(posedge clk) begin
        if (!rst_n)                mar <= '0;
        else if (ctl.mar_from_pc)  mar <= pc;
        else if (ctl.mar_from_tmp) mar <= {th, tl};
    end

    // Data latch: captures read data or the accumulator for a store.
    always_ff @(posedge clk) begin
        if (!rst_n)                mbr <= '0;
        else if (ctl.mbr_from_mem) mbr <= mem_rdata;
        else if (ctl.mbr_from_ac)  mbr <= ac;
    end

    // Instruction latch and the two halves of the operand address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ir <= '0;
            tl <= '0;
            th <= '0;
        end else begin
            if (ctl.ir_ld) ir <= mbr;
            if (ctl.tl_ld) tl <= mbr;
            if (ctl.th_ld) th <= mbr;
        end
    end

    // Accumulator and carry: load immediate or add with carry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ac <= '0;
            cf <= 1'b0;
        end else if (ctl.ac_from_mbr) begin
            ac <= mbr;
        end else if (ctl.ac_add) begin
            ac <= sum;
            cf <= co;
        end
    end

    assign mem_addr  = mar;
    assign mem_wdata = mbr;

    assert_pc_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.pc_inc |=> pc == $past(pc) + AW'(1));
    assert_adc_math_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.ac_add |=> {cf, ac} == ({1'b0, $past(ac)} + {1'b0, $past(mbr)} + {{DW{1'b0}}, $past(cf)}));
    assert_ldi_keeps_carry_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.ac_from_mbr |=> (cf == $past(cf)) && (ac == $past(mbr)));
    assert_store_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.wr |-> mem_wdata == ac);
    assert_store_keeps_state_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.wr |=> (ac == $past(ac)) && (cf == $past(cf)));

endmodule

// File: rtl/acc_cpu.sv
// Top: joins the sequencer and the datapath and exposes one synchronous
// memory port. Assumes memory returns read data the cycle after mem_rd.
module acc_cpu
    import acc_cpu_pkg::*;
#(
    parameter logic [AW-1:0] RESET_PC = 16'h0100
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic          halted
);

    ctl_t          ctl;
    logic [DW-1:0] mbr, ir;

    acc_cpu_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .mbr(mbr), .ir(ir),
        .ctl(ctl), .halted(halted)
    );

    acc_cpu_dpath #(.RESET_PC(RESET_PC)) u_dpath (
        .clk(clk), .rst_n(rst_n), .ctl(ctl), .mem_rdata(mem_rdata),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mbr(mbr), .ir(ir)
    );

    assign mem_rd = ctl.rd;
    assign mem_wr = ctl.wr;

endmodule

// File: tb/tb_acc_cpu.sv
`timescale 1ns/1ps
module tb_acc_cpu;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata;
    logic        mem_rd, mem_wr, halted;

    always #2 clk = ~clk;

    acc_cpu dut (
        .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_rd(mem_rd), .mem_wr(mem_wr), .halted(halted)
    );

    // Sparse memory: program page 0x01xx and data page 0x20xx.
    logic [7:0]  mem [512];
    logic        ld_en = 1'b0;
    logic [15:0] ld_addr = '0;
    logic [7:0]  ld_data = '0;
    logic        clr = 1'b0;
    int          rd_cnt, wr_cnt, dbl_rd, both;
    logic        prev_rd;
    logic [15:0] last_rd;

    function automatic logic [8:0] idx(input logic [15:0] a);
        return {a[13], a[7:0]};
    endfunction

    always @(posedge clk) begin
        if (ld_en) mem[idx(ld_addr)] <= ld_data;
        if (clr) begin
            rd_cnt <= 0; wr_cnt <= 0; dbl_rd <= 0; both <= 0;
            prev_rd <= 1'b0; last_rd <= '0;
        end else begin
            prev_rd <= mem_rd;
            if (mem_rd) begin
                mem_rdata <= mem[idx(mem_addr)];
                rd_cnt    <= rd_cnt + 1;
                last_rd   <= mem_addr;
            end
            if (mem_wr) begin
                mem[idx(mem_addr)] <= mem_wdata;
                wr_cnt <= wr_cnt + 1;
            end
            if (mem_rd && prev_rd) dbl_rd <= dbl_rd + 1;
            if (mem_rd && mem_wr)  both   <= both + 1;
        end
    end

    int n_chk = 0, n_fail = 0, cyc = 0;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            $display("FAIL watchdog: run did not finish act=%0d exp=<150000", cyc);
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail + 1);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    task automatic poke(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        ld_en = 1'b1; ld_addr = a; ld_data = d;
    endtask

    logic [15:0] pp;
    task automatic emit(input logic [7:0] d);
        poke(pp, d);
        pp = pp + 16'd1;
    endtask

    task automatic begin_load();
        @(negedge clk);
        rst_n = 1'b0; clr = 1'b1; pp = 16'h0100;
    endtask

    task automatic release_run();
        @(negedge clk);
        ld_en = 1'b0; clr = 1'b0; rst_n = 1'b1;
    endtask

    task automatic wait_halt(input string req);
        for (int i = 0; i < 2000 && !halted; i++) @(negedge clk);
        chk(halted === 1'b1, req, "halt reached", {31'd0, halted}, 1);
    endtask

    function automatic logic [7:0] rdm(input logic [15:0] a);
        return mem[idx(a)];
    endfunction

    // a, b, carry-in
    localparam int NV = 7;
    localparam logic [16:0] VECS [NV] = '{
        {8'h23, 8'h10, 1'b0}, {8'hFF, 8'h01, 1'b0}, {8'h80, 8'h80, 1'b1},
        {8'h7F, 8'h80, 1'b1}, {8'h00, 8'h00, 1'b1}, {8'hFE, 8'h01, 1'b1},
        {8'h12, 8'h34, 1'b0}
    };

    logic [7:0] va, vb;
    logic       vc;
    logic [8:0] s;

    initial begin
        // ---------- vector table ----------
        for (int i = 0; i < NV; i++) begin
            {va, vb, vc} = VECS[i];
            s = {1'b0, va} + {1'b0, vb} + {8'd0, vc};
            begin_load();
            emit(8'h9A); emit(vc ? 8'hFF : 8'h00);     // set carry via prep
            emit(8'h8A); emit(8'h47); emit(8'h20);
            emit(8'h9A); emit(va);
            emit(8'h8A); emit(8'h43); emit(8'h20);
            emit(8'h84); emit(8'h44); emit(8'h20);
            emit(8'h84); emit(8'h48); emit(8'h20);
            emit(8'h9A); emit(8'h00);
            emit(8'h8A); emit(8'h45); emit(8'h20);
            emit(8'h84); emit(8'h46); emit(8'h20);
            emit(8'hFF);
            poke(16'h2043, vb); poke(16'h2045, 8'h00); poke(16'h2047, 8'h01);
            poke(16'h2044, 8'hEE); poke(16'h2046, 8'hEE); poke(16'h2048, 8'hEE);
            release_run();
            wait_halt("R6");
            chk(rdm(16'h2044) == s[7:0], "R4", "sum stored", {24'd0, rdm(16'h2044)}, {24'd0, s[7:0]});
            chk(rdm(16'h2048) == s[7:0], "R5", "second store same AC", {24'd0, rdm(16'h2048)}, {24'd0, s[7:0]});
            chk(rdm(16'h2046) == {7'd0, s[8]}, "R3", "carry kept over load/store (R4 carry out)",
                {24'd0, rdm(16'h2046)}, {31'd0, s[8]});
            chk(rd_cnt == 28, "R7", "read count", rd_cnt, 28);
            chk(wr_cnt == 3, "R5", "write count", wr_cnt, 3);
            chk(last_rd == 16'h0118, "R7", "halt opcode address", {16'd0, last_rd}, 32'h0118);
            chk(dbl_rd == 0 && both == 0, "R2", "strobe shape", dbl_rd + both, 0);
        end

        // ---------- directed: leave AC=55, carry=1, then halt ----------
        begin_load();
        emit(8'h9A); emit(8'hFF);
        emit(8'h8A); emit(8'h47); emit(8'h20);
        emit(8'h9A); emit(8'h55);
        emit(8'hFF);
        poke(16'h2047, 8'h01);
        release_run();
        wait_halt("R6");

        // halt is sticky and silent
        begin
            int r0, strobes;
            r0 = rd_cnt; strobes = 0;
            for (int k = 0; k < 50; k++) begin
                @(negedge clk);
                if (mem_rd || mem_wr || !halted) strobes++;
            end
            chk(strobes == 0, "R6", "activity while halted", strobes, 0);
            chk(rd_cnt == r0, "R6", "reads while halted", rd_cnt, r0);
        end

        // reset clears halt, AC and carry; restart at 0x0100
        begin_load();
        emit(8'h84); emit(8'h50); emit(8'h20);
        emit(8'h8A); emit(8'h45); emit(8'h20);
        emit(8'h84); emit(8'h51); emit(8'h20);
        emit(8'hFF);
        poke(16'h2045, 8'h00); poke(16'h2050, 8'hEE); poke(16'h2051, 8'hEE);
        @(negedge clk);
        chk(halted == 1'b0, "R8", "halt cleared by reset", {31'd0, halted}, 0);
        chk(!mem_rd && !mem_wr, "R1", "no strobe in reset", {30'd0, mem_rd, mem_wr}, 0);
        release_run();
        @(negedge clk);
        chk(mem_rd == 1'b1 && mem_addr == 16'h0100, "R1", "first fetch at reset vector",
            {15'd0, mem_rd, mem_addr}, 32'h1_0100);
        wait_halt("R8");
        chk(rdm(16'h2050) == 8'h00, "R1", "AC cleared", {24'd0, rdm(16'h2050)}, 0);
        chk(rdm(16'h2051) == 8'h00, "R1", "carry cleared", {24'd0, rdm(16'h2051)}, 0);
        chk(last_rd == 16'h0109, "R7", "PC after two stores and add", {16'd0, last_rd}, 32'h0109);

        // undefined opcodes halt right after their fetch
        begin
            logic [7:0] bad [5] = '{8'h00, 8'h9B, 8'h8B, 8'h85, 8'hFF};
            for (int j = 0; j < 5; j++) begin
                begin_load();
                emit(bad[j]);
                release_run();
                wait_halt("R6");
                chk(rd_cnt == 1 && wr_cnt == 0, "R6", "single fetch then halt",
                    rd_cnt * 16 + wr_cnt, 16);
            end
        end

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule